// File: doc/BRIEF.md
# Serial Bit Destuffer

This block sits between a bit-timing sampler and a frame parser on a serial field bus that uses NRZ line coding. Each sampled line bit arrives as a one-cycle strobe with its value. The block keeps a short history of the raw bits it has received, and this history includes the bits it removes. When the five raw bits before a new bit all carry the same value and the new bit has the opposite value, the new bit is an inserted stuff bit. The block reports that bit on a side flag and does not pass it on. Every other bit goes to the parser one cycle later, so stuff bits never advance the parser's frame-bit count.

The parser opens the stuffing window with an enable input. It raises the enable at start of frame and drops it after the checksum sequence. While the enable is low, bits pass straight through and the history stays empty. While the enable is high, a sixth bit equal to the five before it breaks the stuffing rule. The block raises a one-cycle error pulse for that bit and starts the history again. A frame-start input also empties the history.

Top module: `nrz_destuffer`

## Requirements
- R1: After reset, outValid, stuffFlag and stuffErr are all low.
- R2: While stuffEn is low, every input bit appears on outValid/outBit in the next cycle with its value unchanged, stuffFlag and stuffErr stay low, and no bit is ever judged to be stuff.
- R3: While stuffEn is high, a bit whose five preceding raw history bits are all equal and whose value differs from them gives a one-cycle stuffFlag pulse in the next cycle, and outValid stays low in that cycle.
- R4: While stuffEn is high, every bit that is neither stuff nor an error is forwarded in the next cycle with its value, in arrival order.
- R5: Stuff bits enter the raw history. A stuff bit therefore counts as the first bit of a new run. After 0,0,0,0,0 then a stuff 1, four further 1s followed by a 0 make that 0 a stuff bit.
- R6: While stuffEn is high, a bit equal to five equal preceding history bits gives a one-cycle stuffErr pulse in the next cycle. The bit is not forwarded and the history becomes empty.
- R7: frameStart empties the history. A bit arriving in the same cycle is judged against the empty history and becomes its first entry.
- R8: While stuffEn is low the history is held empty. After stuffEn rises, a run must rebuild from bits received while enabled before a stuff bit can be recognised.
- R9: In a cycle after one with inValid low, outValid, stuffFlag and stuffErr are all low.
- R10: At most one of outValid, stuffFlag and stuffErr is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stuffEn | input | 1 | Stuffing window open (from parser) |
| frameStart | input | 1 | Empties the raw history |
| inValid | input | 1 | Sampled bit strobe |
| inBit | input | 1 | Sampled bit value |
| outValid | output | 1 | Forwarded frame-bit strobe |
| outBit | output | 1 | Forwarded frame-bit value |
| stuffFlag | output | 1 | Received bit was a stuff bit |
| stuffErr | output | 1 | Stuffing rule violated |

## Verification
Two things can happen in the same cycle: frameStart can clear the history while a new bit is judged against it. The bench drives frameStart together with a bit right after a run of five equal bits. A correct design forwards that bit instead of flagging it, and it counts a fresh run from there. A behavioural queue model in the bench predicts every output in every cycle. Randomised traffic with long runs, gaps, enable toggles and frame starts keeps placing these events side by side.

// File: rtl/destuff_pkg.sv
`timescale 1ns/1ps
package destuff_pkg;
  // Per-bit decision strobes from control to datapath.
  typedef struct packed {
    logic push;   // shift the current bit into the raw history
    logic clear;  // empty the raw history (applied before push)
    logic fwd;    // forward the current bit as a frame bit
    logic stuff;  // current bit is a stuff bit
    logic err;    // current bit breaks the stuffing rule
  } dsStrobe_t;
endpackage

// File: rtl/destuff_ctrl.sv
`timescale 1ns/1ps
module destuff_ctrl
  import destuff_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stuffEn,
  input  logic      frameStart,
  input  logic      inValid,
  input  logic      inBit,
  input  logic      runHit,
  input  logic      histLast,
  output dsStrobe_t strb
);

  // A full run only counts when the history is not being emptied this cycle.
  logic runLive;
  assign runLive = runHit && !frameStart;

  always_comb begin
    strb = '0;
    if (!stuffEn) begin
      strb.clear = 1'b1;
      strb.fwd   = inValid;
    end else begin
      strb.clear = frameStart;
      if (inValid) begin
        if (runLive) begin
          if (inBit != histLast) begin
            strb.stuff = 1'b1;
            strb.push  = 1'b1;
          end else begin
            strb.err   = 1'b1;
            strb.clear = 1'b1;
          end
        end else begin
          strb.fwd  = 1'b1;
          strb.push = 1'b1;
        end
      end
    end
  end

  // R10: one outcome per bit at most
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fwd, strb.stuff, strb.err}));

  // R6: an error never keeps history
  assert_err_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.err |-> (strb.clear && !strb.push));

endmodule

// File: rtl/destuff_dp.sv
`timescale 1ns/1ps
module destuff_dp
  import destuff_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  dsStrobe_t strb,
  input  logic      inBit,
  output logic      runHit,
  output logic      histLast,
  output logic      outValid,
  output logic      outBit,
  output logic      stuffFlag,
  output logic      stuffErr
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

  logic [RUN_LEN-1:0] window;   // window[0] is the newest raw bit
  logic [CNT_W-1:0]   fill;
  logic [CNT_W-1:0]   fillBase;
  logic [CNT_W-1:0]   fillNext;

  assign fillBase = strb.clear ? '0 : fill;
  assign fillNext = (fillBase == FULL) ? FULL : fillBase + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      window <= '0;
      fill   <= '0;
    end else if (strb.push) begin
      window <= {window[RUN_LEN-2:0], inBit};
      fill   <= fillNext;
    end else if (strb.clear) begin
      fill   <= '0;
    end
  end

  assign runHit   = (fill == FULL) && ((&window) || (~|window));
  assign histLast = window[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outBit    <= 1'b0;
      stuffFlag <= 1'b0;
      stuffErr  <= 1'b0;
    end else begin
      outValid  <= strb.fwd;
      outBit    <= strb.fwd ? inBit : 1'b0;
      stuffFlag <= strb.stuff;
      stuffErr  <= strb.err;
    end
  end

  // R5: history length never passes the run length
  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FULL);

  // R3: a stuff decision leaves a one-entry-or-longer history
  assert_stuff_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.stuff |=> (fill != '0));

endmodule

// File: rtl/nrz_destuffer.sv
`timescale 1ns/1ps
module nrz_destuffer
  import destuff_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic stuffEn,
  input  logic frameStart,
  input  logic inValid,
  input  logic inBit,
  output logic outValid,
  output logic outBit,
  output logic stuffFlag,
  output logic stuffErr
);

  dsStrobe_t strb;
  logic      runHit;
  logic      histLast;

  destuff_ctrl ctrl_i (
    .clk, .rstN, .stuffEn, .frameStart, .inValid, .inBit,
    .runHit, .histLast, .strb
  );

  destuff_dp #(.RUN_LEN(RUN_LEN)) dp_i (
    .clk, .rstN, .strb, .inBit, .runHit, .histLast,
    .outValid, .outBit, .stuffFlag, .stuffErr
  );

  assert_out_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outValid, stuffFlag, stuffErr}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !(outValid || stuffFlag || stuffErr));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !stuffEn) |=> (outValid && (outBit == $past(inBit))));

  assert_every_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outValid || stuffFlag || stuffErr));

  assert_stuff_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (stuffFlag || stuffErr) |-> $past(stuffEn));

endmodule

// File: tb/nrz_destuffer_tb.sv
`timescale 1ns/1ps
module nrz_destuffer_tb_top;

  logic clk = 1'b0;
  logic rstN;
  logic stuffEn, frameStart, inValid, inBit;
  logic outValid, outBit, stuffFlag, stuffErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nrz_destuffer dut_i (
    .clk, .rstN, .stuffEn, .frameStart, .inValid, .inBit,
    .outValid, .outBit, .stuffFlag, .stuffErr
  );

  // Behavioural reference: a queue of raw history bits.
  int    hist[$];
  logic  eV, eB, eS, eE;
  string curReq = "R1";

  function automatic bit lastFiveEqual();
    if (hist.size() < 5) return 0;
    for (int k = 1; k < 5; k++)
      if (hist[hist.size()-1-k] != hist[hist.size()-1]) return 0;
    return 1;
  endfunction

  task automatic compare();
    checks++;
    if (eV !== outValid || eS !== stuffFlag || eE !== stuffErr ||
        (eV && eB !== outBit)) begin
      errors++;
      $display("FAIL %s: got v=%0b b=%0b s=%0b e=%0b exp v=%0b b=%0b s=%0b e=%0b",
               curReq, outValid, outBit, stuffFlag, stuffErr, eV, eB, eS, eE);
    end
  endtask

  task automatic sendBit(input logic fs, input logic en, input logic v, input logic b);
    @(negedge clk);
    compare();
    frameStart = fs; stuffEn = en; inValid = v; inBit = b;
    eV = 0; eB = 0; eS = 0; eE = 0;
    if (!en) begin
      hist.delete();
      if (v) begin eV = 1; eB = b; end
    end else begin
      if (fs) hist.delete();
      if (v) begin
        if (lastFiveEqual()) begin
          if (b != hist[hist.size()-1]) begin
            eS = 1; hist.push_back(b);
          end else begin
            eE = 1; hist.delete();
          end
        end else begin
          eV = 1; eB = b; hist.push_back(b);
        end
        if (hist.size() > 6) void'(hist.pop_front());
      end
    end
  endtask

  task automatic sendRun(input logic en, input logic b, input int n);
    for (int k = 0; k < n; k++) sendBit(0, en, 1, b);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; stuffEn = 0; frameStart = 0; inValid = 0; inBit = 0;
    eV = 0; eB = 0; eS = 0; eE = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1: reset state
    curReq = "R1";
    sendBit(0, 0, 0, 0);

    // R2: bypass while disabled, long equal runs never flagged
    curReq = "R2";
    sendRun(0, 1, 8);
    sendRun(0, 0, 7);
    sendBit(0, 0, 1, 1);

    // R3 / R7: frame opens, five zeros then opposite bit is stuff
    curReq = "R3";
    sendBit(1, 1, 1, 0);
    sendRun(1, 0, 4);
    sendBit(0, 1, 1, 1);
    // R4: normal bits forwarded in order
    curReq = "R4";
    sendBit(0, 1, 1, 0);
    sendBit(0, 1, 1, 1);
    sendBit(0, 1, 0, 0);
    sendBit(0, 1, 1, 1);

    // R5: stuff bit opens a new run
    curReq = "R5";
    sendBit(1, 1, 1, 0);
    sendRun(1, 0, 4);
    sendBit(0, 1, 1, 1);      // stuff
    sendRun(1, 1, 4);
    sendBit(0, 1, 1, 0);      // stuff again thanks to counted stuff bit

    // R6: six equal bits raise error and clear history
    curReq = "R6";
    sendBit(1, 1, 1, 1);
    sendRun(1, 1, 4);
    sendBit(0, 1, 1, 1);      // error
    sendBit(0, 1, 1, 0);      // forwarded, history restarted

    // R7: frameStart in same cycle as the bit after a full run
    curReq = "R7";
    sendBit(1, 1, 1, 0);
    sendRun(1, 0, 4);
    sendBit(1, 1, 1, 1);      // forwarded, first of new history
    sendRun(1, 1, 4);
    sendBit(0, 1, 1, 0);      // stuff after five ones

    // R8: disabling empties history
    curReq = "R8";
    sendBit(1, 1, 1, 0);
    sendRun(1, 0, 3);
    sendBit(0, 0, 1, 0);
    sendBit(0, 1, 1, 0);
    sendBit(0, 1, 1, 1);      // forwarded: run rebuilt from 1 bit only

    // R9: gaps
    curReq = "R9";
    sendBit(0, 1, 0, 1);
    sendBit(0, 1, 0, 0);

    // R10 and all above: randomised traffic with long runs
    curReq = "R10";
    for (int i = 0; i < 4000; i++) begin
      logic en, fs, v, b;
      en = ($urandom_range(99) == 0) ? !stuffEn : stuffEn;
      fs = ($urandom_range(59) == 0);
      v  = ($urandom_range(9) < 7);
      b  = ($urandom_range(9) < 8) ? inBit : !inBit;
      sendBit(fs, en, v, b);
    end
    sendBit(0, 0, 0, 0);
    @(negedge clk);
    compare();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule